// File: doc/BRIEF.md
# Multi-source open-drain status pin controller

This block decides, on every system clock, what a single open-drain status line shows to the host controller that reads it. A 3-bit source select picks among idle release, a low level while the PLL reports loss of lock, a low level that marks the end of an IF frequency count, or a mirror of one of two general I/O pins. Serial bus activity overrides the select: while chip-enable is high, the line is either released (data being written into the device) or carries the shifted serial output bit (data being read out).

The line is presented as two registered signals, `drive_low` and `released`, which a pad cell turns into the open-drain pin. Every output reflects the inputs that were present at the previous rising clock edge. The count-completion indication is stored in a small tracker, so a short done pulse leaves the line low until a new count is started or a serial transfer begins.

Top module: `stpin_ctrl`

## Requirements
- R1: After synchronous reset the line is released (`released`=1, `drive_low`=0) and the stored count-completion flag is clear.
- R2: With chip-enable low, select codes 3'b000, 3'b011, 3'b100 and 3'b111 release the line.
- R3: With chip-enable low and select 3'b001, the line is driven low exactly when `unlock` is 1 and released otherwise.
- R4: With select 3'b010, a `cnt_done` pulse sets the stored completion flag and the line is driven low; the low level is held after `cnt_done` falls.
- R5: A 0-to-1 transition of `cnt_en` (compared with its value at the previous clock edge) clears the stored completion flag and releases the line in count mode; it wins over a `cnt_done` in the same cycle.
- R6: Chip-enable high clears the stored completion flag, so after the transfer ends the line stays released in count mode until the next `cnt_done`.
- R7: With chip-enable low, select 3'b101 mirrors I/O pin 0 and 3'b110 mirrors I/O pin 1 when that pin is an input (`io_is_out` bit 0): the line is low when `io_level` is 0 and released when it is 1.
- R8: In a mirror mode whose I/O pin is an output (`io_is_out` bit 1), the line is released whatever its level.
- R9: While chip-enable is high with `xfer_mode` 2'b00, 2'b01 or 2'b11 (write transfers), the line is released regardless of the select.
- R10: While chip-enable is high with `xfer_mode` 2'b10 (read transfer), the line is driven low when `ser_bit` is 0 and released when it is 1, regardless of the select.
- R11: Exactly one of `drive_low` and `released` is 1 in every cycle, and both change one clock after the inputs that cause the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 3 | Source select code |
| unlock | input | 1 | PLL loss-of-lock flag |
| cnt_en | input | 1 | IF count enable bit |
| cnt_done | input | 1 | IF count finished pulse |
| io_level | input | NUM_IO | Levels of the general I/O pins |
| io_is_out | input | NUM_IO | 1 when the I/O pin is configured as an output |
| ce | input | 1 | Serial bus chip-enable |
| xfer_mode | input | 2 | Serial transfer mode (2'b10 read, others write) |
| ser_bit | input | 1 | Serial output bit from the shift register |
| drive_low | output | 1 | 1 to pull the open-drain line low |
| released | output | 1 | 1 when the line is released |

## Verification
The bench builds the block with its default of two mirrored I/O pins, which places both mirror codes and every release-only code within reach of the select stimulus. A behavioural model tracks the completion flag and the previous count enable, so directed sequences can reach the edge-versus-done collision, a clear by chip-enable followed by a quiet count mode, and mirror pins switching between input and output. Random phases then mix transfers of every mode with all select codes.

// File: rtl/stpin_pkg.sv
package stpin_pkg;

    typedef enum logic [2:0] {
        SEL_OFF0   = 3'd0,
        SEL_UNLOCK = 3'd1,
        SEL_COUNT  = 3'd2,
        SEL_OFF3   = 3'd3,
        SEL_OFF4   = 3'd4,
        SEL_IO0    = 3'd5,
        SEL_IO1    = 3'd6,
        SEL_OFF7   = 3'd7
    } src_sel_e;

    typedef enum logic [1:0] {
        XF_WR_A = 2'd0,
        XF_WR_B = 2'd1,
        XF_RD   = 2'd2,
        XF_WR_C = 2'd3
    } xfer_e;

    typedef enum logic {
        PIN_REL = 1'b0,
        PIN_LOW = 1'b1
    } pin_e;

    typedef struct packed {
        logic active;
        pin_e level;
    } bus_req_t;

    localparam int SEL_W   = 3;
    localparam int IO_BASE = 5;

    function automatic pin_e low_when(input logic cond);
        return cond ? PIN_LOW : PIN_REL;
    endfunction

endpackage

// File: rtl/stpin_count_tracker.sv
module stpin_count_tracker (
    input  logic clk,
    input  logic rst,
    input  logic cnt_en,
    input  logic cnt_done,
    input  logic ce,
    output logic done_next,
    output logic done_q
);
    logic en_prev_q;
    logic en_rise;

    assign en_rise = cnt_en & ~en_prev_q;

    always_comb begin
        if (en_rise || ce)
            done_next = 1'b0;
        else if (cnt_done)
            done_next = 1'b1;
        else
            done_next = done_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_prev_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            en_prev_q <= cnt_en;
            done_q    <= done_next;
        end
    end

    // R4: a done pulse with no clearing condition leaves the flag set
    a_r4_done_sets: assert property (@(posedge clk) disable iff (rst)
        (cnt_done && !ce && !(cnt_en && !en_prev_q)) |=> done_q);

    // R5: rising enable clears the flag
    a_r5_rise_clears: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !en_prev_q) |=> !done_q);

    // R6: chip-enable clears the flag
    a_r6_ce_clears: assert property (@(posedge clk) disable iff (rst)
        ce |=> !done_q);

endmodule

// File: rtl/stpin_source_mux.sv
module stpin_source_mux
    import stpin_pkg::*;
#(
    parameter int NUM_IO = 2
) (
    input  logic [SEL_W-1:0]  src_sel,
    input  logic              unlock,
    input  logic              done_next,
    input  logic [NUM_IO-1:0] io_level,
    input  logic [NUM_IO-1:0] io_is_out,
    output pin_e              sel_level
);
    localparam int MAX_IO = (1 << SEL_W) - IO_BASE;

    pin_e      io_pin [NUM_IO];
    src_sel_e  sel_e;

    assign sel_e = src_sel_e'(src_sel);

    generate
        if (NUM_IO < 1 || NUM_IO > MAX_IO) begin : g_bad_count
            initial $error("NUM_IO out of range");
        end
        for (genvar k = 0; k < NUM_IO; k++) begin : g_mirror
            assign io_pin[k] = low_when(!io_is_out[k] && !io_level[k]);
        end
    endgenerate

    always_comb begin
        sel_level = PIN_REL;
        case (sel_e)
            SEL_UNLOCK: sel_level = low_when(unlock);
            SEL_COUNT:  sel_level = low_when(done_next);
            default: begin
                for (int k = 0; k < NUM_IO; k++) begin
                    if (int'(src_sel) == IO_BASE + k)
                        sel_level = io_pin[k];
                end
            end
        endcase
    end

endmodule

// File: rtl/stpin_bus_override.sv
module stpin_bus_override
    import stpin_pkg::*;
(
    input  logic       ce,
    input  logic [1:0] xfer_mode,
    input  logic       ser_bit,
    input  pin_e       sel_level,
    output pin_e       pin_next
);
    bus_req_t req;

    always_comb begin
        req.active = ce;
        if (xfer_e'(xfer_mode) == XF_RD)
            req.level = low_when(!ser_bit);
        else
            req.level = PIN_REL;
        pin_next = req.active ? req.level : sel_level;
    end

endmodule

// File: rtl/stpin_ctrl.sv
module stpin_ctrl
    import stpin_pkg::*;
#(
    parameter int NUM_IO = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        src_sel,
    input  logic              unlock,
    input  logic              cnt_en,
    input  logic              cnt_done,
    input  logic [NUM_IO-1:0] io_level,
    input  logic [NUM_IO-1:0] io_is_out,
    input  logic              ce,
    input  logic [1:0]        xfer_mode,
    input  logic              ser_bit,
    output logic              drive_low,
    output logic              released
);
    logic done_next;
    logic done_q;
    pin_e sel_level;
    pin_e pin_next;
    pin_e pin_q;

    stpin_count_tracker u_track (
        .clk       (clk),
        .rst       (rst),
        .cnt_en    (cnt_en),
        .cnt_done  (cnt_done),
        .ce        (ce),
        .done_next (done_next),
        .done_q    (done_q)
    );

    stpin_source_mux #(.NUM_IO(NUM_IO)) u_mux (
        .src_sel   (src_sel),
        .unlock    (unlock),
        .done_next (done_next),
        .io_level  (io_level),
        .io_is_out (io_is_out),
        .sel_level (sel_level)
    );

    stpin_bus_override u_bus (
        .ce        (ce),
        .xfer_mode (xfer_mode),
        .ser_bit   (ser_bit),
        .sel_level (sel_level),
        .pin_next  (pin_next)
    );

    always_ff @(posedge clk) begin
        if (rst) pin_q <= PIN_REL;
        else     pin_q <= pin_next;
    end

    assign drive_low = (pin_q == PIN_LOW);
    assign released  = (pin_q == PIN_REL);

    // R9: write transfer releases the line
    a_r9_write_release: assert property (@(posedge clk) disable iff (rst)
        (ce && xfer_mode != 2'b10) |=> released);

    // R10: read transfer follows the serial bit
    a_r10_read_bit: assert property (@(posedge clk) disable iff (rst)
        (ce && xfer_mode == 2'b10) |=> (drive_low == !$past(ser_bit)));

    // R2: idle codes release the line
    a_r2_idle_release: assert property (@(posedge clk) disable iff (rst)
        (!ce && (src_sel == 3'd0 || src_sel == 3'd3 || src_sel == 3'd4 || src_sel == 3'd7))
        |=> released);

    // R3: unlock mode follows the flag
    a_r3_unlock: assert property (@(posedge clk) disable iff (rst)
        (!ce && src_sel == 3'd1) |=> (drive_low == $past(unlock)));

    // R11: exactly one output active
    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot({drive_low, released}));

endmodule

// File: tb/stpin_ctrl_bench.sv
module stpin_ctrl_bench;
    localparam int NUM_IO = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] src_sel = 3'd0;
    logic unlock = 1'b0, cnt_en = 1'b0, cnt_done = 1'b0;
    logic [NUM_IO-1:0] io_level = '1, io_is_out = '0;
    logic ce = 1'b0;
    logic [1:0] xfer_mode = 2'b00;
    logic ser_bit = 1'b1;
    logic drive_low, released;

    int checks = 0, fails = 0, cycles = 0;

    // reference model state
    bit  m_lat = 0, m_prev_en = 0, m_ce_cleared = 0;
    bit  exp_low = 0;
    string exp_tag = "R1";

    always #5 clk = ~clk;

    stpin_ctrl #(.NUM_IO(NUM_IO)) u_stpin_ctrl (
        .clk(clk), .rst(rst), .src_sel(src_sel), .unlock(unlock),
        .cnt_en(cnt_en), .cnt_done(cnt_done), .io_level(io_level),
        .io_is_out(io_is_out), .ce(ce), .xfer_mode(xfer_mode),
        .ser_bit(ser_bit), .drive_low(drive_low), .released(released)
    );

    always @(posedge clk) begin
        bit rise;
        bit lat_n;
        cycles++;
        if (rst) begin
            m_lat = 0; m_prev_en = 0; m_ce_cleared = 0;
            exp_low = 0; exp_tag = "R1";
        end else begin
            rise = cnt_en && !m_prev_en;
            lat_n = m_lat;
            if (rise || ce) begin
                if (ce && m_lat) m_ce_cleared = 1;
                if (rise) m_ce_cleared = 0;
                lat_n = 0;
            end else if (cnt_done) begin
                lat_n = 1;
                m_ce_cleared = 0;
            end
            if (ce) begin
                if (xfer_mode == 2'b10) begin exp_low = !ser_bit; exp_tag = "R10"; end
                else begin exp_low = 0; exp_tag = "R9"; end
            end else begin
                case (src_sel)
                    3'd1: begin exp_low = unlock; exp_tag = "R3"; end
                    3'd2: begin
                        exp_low = lat_n;
                        exp_tag = rise ? "R5" : (m_ce_cleared ? "R6" : "R4");
                    end
                    3'd5, 3'd6: begin
                        int k;
                        k = int'(src_sel) - 5;
                        if (io_is_out[k]) begin exp_low = 0; exp_tag = "R8"; end
                        else begin exp_low = !io_level[k]; exp_tag = "R7"; end
                    end
                    default: begin exp_low = 0; exp_tag = "R2"; end
                endcase
            end
            m_lat = lat_n;
            m_prev_en = cnt_en;
        end
    end

    always @(negedge clk) begin
        if (cycles > 0) begin
            checks++;
            if (drive_low !== exp_low || released !== !exp_low) begin
                fails++;
                $display("FAIL %s: drive_low=%0b released=%0b expected drive_low=%0b released=%0b",
                         exp_tag, drive_low, released, exp_low, !exp_low);
            end
            checks++;
            if (drive_low === released) begin
                fails++;
                $display("FAIL R11: drive_low=%0b released=%0b expected complementary",
                         drive_low, released);
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        // R2 idle codes
        src_sel = 3'd0; step(2);
        src_sel = 3'd3; step(2);
        src_sel = 3'd4; step(2);
        src_sel = 3'd7; step(2);
        // R3 unlock mode
        src_sel = 3'd1; unlock = 1; step(2); unlock = 0; step(2);
        // R4 count completion held
        src_sel = 3'd2; cnt_en = 1; step(2);
        cnt_done = 1; step(1); cnt_done = 0; step(4);
        // R5 restart clears
        cnt_en = 0; step(1); cnt_en = 1; step(2);
        cnt_done = 1; step(1); cnt_done = 0; step(2);
        cnt_en = 0; step(1); cnt_en = 1; cnt_done = 1; step(1);
        cnt_done = 0; step(2);
        // R6 chip-enable clears
        cnt_done = 1; step(1); cnt_done = 0; step(2);
        ce = 1; xfer_mode = 2'b00; step(2); ce = 0; step(3);
        // R7 / R8 mirrors
        src_sel = 3'd5; io_level = 2'b10; step(2); io_level = 2'b11; step(2);
        io_is_out = 2'b01; io_level = 2'b00; step(2);
        src_sel = 3'd6; io_is_out = 2'b00; step(2); io_level = 2'b10; step(2);
        io_is_out = 2'b10; io_level = 2'b00; step(2);
        io_is_out = 2'b00;
        // R9 / R10 transfers override
        src_sel = 3'd1; unlock = 1;
        ce = 1; xfer_mode = 2'b01; step(2); xfer_mode = 2'b11; step(2);
        xfer_mode = 2'b10;
        for (int i = 0; i < 8; i++) begin ser_bit = i[0]; step(1); end
        ce = 0; step(2);
        // random mixing
        for (int i = 0; i < 3000; i++) begin
            src_sel   = 3'($urandom);
            unlock    = 1'($urandom);
            cnt_en    = ($urandom % 4) != 0 ? cnt_en : ~cnt_en;
            cnt_done  = ($urandom % 6) == 0;
            io_level  = NUM_IO'($urandom);
            io_is_out = NUM_IO'($urandom);
            ce        = ($urandom % 5) == 0;
            xfer_mode = 2'($urandom);
            ser_bit   = 1'($urandom);
            step(1);
        end
        ce = 0; cnt_done = 0;
        // R1 reset returns to released
        rst = 1; step(2);
        rst = 0; src_sel = 3'd2; step(2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule